// File: doc/BRIEF.md
# Cascaded Interrupt Vector Generator

This block sits next to a pair of interrupt priority resolvers that are wired as a two-level cascade. The second-level (slave) resolver drives input line 2 of the first-level (master) resolver. When the processor side raises an acknowledge request, the block looks at the winners the two resolvers present at that moment. From them it decides which resolvers get an acknowledge strobe, and it forms the 8-bit vector number that goes back to the processor.

Each resolver has a 5-bit vector base, which supplies the upper five bits of the vector. The lower three bits always come from a line number. That line number is either the winning line or, when no real winner exists at the level that was consulted, the fixed spurious line 7.

The result is registered. The vector and both strobes appear one clock after the request, together with a single-cycle valid pulse. The priority arbitration inside the resolvers is not part of this block.

Top module: `casc_vec_gen`

## Requirements
- R1: After a synchronous reset, `vec_valid`, `mst_ack`, `slv_ack` and `vec_out` are all 0.
- R2: A request with `mst_valid`=0 yields `vec_out` = {`mst_base`, 3'd7}, with `mst_ack`=0 and `slv_ack`=0.
- R3: A request with `mst_valid`=1 and `mst_line`≠2 yields `vec_out` = {`mst_base`, `mst_line`}, with `mst_ack`=1 and `slv_ack`=0.
- R4: A request with `mst_valid`=1, `mst_line`=2 and `slv_valid`=1 yields `vec_out` = {`slv_base`, `slv_line`}, with `mst_ack`=1 and `slv_ack`=1.
- R5: A request with `mst_valid`=1, `mst_line`=2 and `slv_valid`=0 yields `vec_out` = {`slv_base`, 3'd7}, with `mst_ack`=1 and `slv_ack`=0.
- R6: `vec_valid` is 1 exactly in the cycle after a cycle in which `ack_req` was sampled 1. Back-to-back requests give back-to-back pulses, each carrying its own result.
- R7: `slv_ack` is never 1 unless `mst_ack` is 1 in the same cycle. Both strobes are decided from the winner inputs sampled together with the request.
- R8: In a cycle following no request, both strobes are 0 and `vec_out` keeps the last vector produced, whatever the winner and base inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ack_req | input | 1 | Acknowledge request, one cycle per request |
| mst_valid | input | 1 | Master resolver has a winning line |
| mst_line | input | 3 | Master winning line |
| slv_valid | input | 1 | Slave resolver has a winning line |
| slv_line | input | 3 | Slave winning line |
| mst_base | input | 5 | Master vector base (vector bits 7:3) |
| slv_base | input | 5 | Slave vector base (vector bits 7:3) |
| mst_ack | output | 1 | Acknowledge strobe to the master resolver |
| slv_ack | output | 1 | Acknowledge strobe to the slave resolver |
| vec_out | output | 8 | Vector number |
| vec_valid | output | 1 | Single-cycle vector valid pulse |

## Verification
The hardest case to reach is the slave-level spurious one. It needs a request while the master shows line 2 and the slave shows no winner at the same time. Random stimulus reaches line 2 only one time in eight and then draws the slave valid bit independently.

To cover it reliably, the stimulus biases the master line toward 2 in a share of the random requests. Directed cases also pin the slave-spurious and cascade combinations. A separate set of steps keeps winners and bases changing while no request is made, which checks that the held vector and the idle strobes do not move.

// File: rtl/casc_pkg.sv
package casc_pkg;
  typedef enum logic [1:0] {
    RT_MST_SPUR = 2'd0,
    RT_DIRECT   = 2'd1,
    RT_CASCADE  = 2'd2,
    RT_SLV_SPUR = 2'd3
  } route_e;
endpackage

// File: rtl/cv_route_sel.sv
module cv_route_sel
  import casc_pkg::*;
#(
  parameter int LINE_W    = 3,
  parameter int CASC_LINE = 2
) (
  input  logic              mst_valid,
  input  logic [LINE_W-1:0] mst_line,
  input  logic              slv_valid,
  output route_e            route
);
  localparam logic [LINE_W-1:0] CASC_CODE = LINE_W'(CASC_LINE);

  always_comb begin
    if (!mst_valid)                  route = RT_MST_SPUR;
    else if (mst_line != CASC_CODE)  route = RT_DIRECT;
    else if (slv_valid)              route = RT_CASCADE;
    else                             route = RT_SLV_SPUR;
  end
endmodule

// File: rtl/cv_vec_build.sv
module cv_vec_build
  import casc_pkg::*;
#(
  parameter int LINE_W    = 3,
  parameter int BASE_W    = 5,
  parameter int SPUR_LINE = 7,
  localparam int VEC_W    = BASE_W + LINE_W
) (
  input  route_e            route,
  input  logic [LINE_W-1:0] mst_line,
  input  logic [LINE_W-1:0] slv_line,
  input  logic [BASE_W-1:0] mst_base,
  input  logic [BASE_W-1:0] slv_base,
  output logic [VEC_W-1:0]  vec,
  output logic              mack,
  output logic              sack
);
  localparam logic [LINE_W-1:0] SPUR_CODE = LINE_W'(SPUR_LINE);

  always_comb begin
    // slave strobe is settled first; both come from the same sampled winners
    sack = (route == RT_CASCADE);
    mack = (route != RT_MST_SPUR);
    unique case (route)
      RT_MST_SPUR: vec = {mst_base, SPUR_CODE};
      RT_DIRECT:   vec = {mst_base, mst_line};
      RT_CASCADE:  vec = {slv_base, slv_line};
      default:     vec = {slv_base, SPUR_CODE};
    endcase
  end
endmodule

// File: rtl/cv_out_reg.sv
module cv_out_reg #(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic [VEC_W-1:0] vec_d,
  input  logic             mack_d,
  input  logic             sack_d,
  output logic [VEC_W-1:0] vec_q,
  output logic             mack_q,
  output logic             sack_q,
  output logic             valid_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      vec_q   <= '0;
      mack_q  <= 1'b0;
      sack_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= req;
      mack_q  <= req & mack_d;
      sack_q  <= req & sack_d;
      if (req) vec_q <= vec_d;
    end
  end

  // R6
  pulse_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    req |=> valid_q);
  // R6
  no_pulse_without_req_chk: assert property (@(posedge clk) disable iff (rst)
    !req |=> !valid_q);
  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !req |=> ($stable(vec_q) && !mack_q && !sack_q));
endmodule

// File: rtl/casc_vec_gen.sv
module casc_vec_gen
  import casc_pkg::*;
#(
  parameter int LINE_W    = 3,
  parameter int BASE_W    = 5,
  parameter int CASC_LINE = 2,
  parameter int SPUR_LINE = 7,
  localparam int VEC_W    = BASE_W + LINE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ack_req,
  input  logic              mst_valid,
  input  logic [LINE_W-1:0] mst_line,
  input  logic              slv_valid,
  input  logic [LINE_W-1:0] slv_line,
  input  logic [BASE_W-1:0] mst_base,
  input  logic [BASE_W-1:0] slv_base,
  output logic              mst_ack,
  output logic              slv_ack,
  output logic [VEC_W-1:0]  vec_out,
  output logic              vec_valid
);
  route_e             route;
  logic [VEC_W-1:0]   vec_d;
  logic               mack_d, sack_d;

  cv_route_sel #(.LINE_W(LINE_W), .CASC_LINE(CASC_LINE)) u_route (
    .mst_valid(mst_valid), .mst_line(mst_line), .slv_valid(slv_valid),
    .route(route)
  );

  cv_vec_build #(.LINE_W(LINE_W), .BASE_W(BASE_W), .SPUR_LINE(SPUR_LINE)) u_build (
    .route(route), .mst_line(mst_line), .slv_line(slv_line),
    .mst_base(mst_base), .slv_base(slv_base),
    .vec(vec_d), .mack(mack_d), .sack(sack_d)
  );

  cv_out_reg #(.VEC_W(VEC_W)) u_oreg (
    .clk(clk), .rst(rst), .req(ack_req),
    .vec_d(vec_d), .mack_d(mack_d), .sack_d(sack_d),
    .vec_q(vec_out), .mack_q(mst_ack), .sack_q(slv_ack), .valid_q(vec_valid)
  );

  // R7
  slave_needs_master_chk: assert property (@(posedge clk) disable iff (rst)
    slv_ack |-> mst_ack);
  // R2
  master_spurious_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_req && !mst_valid) |=>
      (vec_out[LINE_W-1:0] == LINE_W'(SPUR_LINE) && !mst_ack && !slv_ack));
  // R4
  cascade_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_req && mst_valid && mst_line == LINE_W'(CASC_LINE) && slv_valid) |=>
      (mst_ack && slv_ack && vec_out[LINE_W-1:0] == $past(slv_line)));
  // R3
  direct_line_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_req && mst_valid && mst_line != LINE_W'(CASC_LINE)) |=>
      (mst_ack && !slv_ack && vec_out == {$past(mst_base), $past(mst_line)}));
  // R5
  slave_spurious_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_req && mst_valid && mst_line == LINE_W'(CASC_LINE) && !slv_valid) |=>
      (mst_ack && !slv_ack && vec_out == {$past(slv_base), LINE_W'(SPUR_LINE)}));
endmodule

// File: tb/test_casc_vec_gen.sv
`timescale 1ns/100ps
module test_casc_vec_gen;
  logic clk = 1'b0, rst = 1'b1;
  logic ack_req = 1'b0, mst_valid = 1'b0, slv_valid = 1'b0;
  logic [2:0] mst_line = '0, slv_line = '0;
  logic [4:0] mst_base = '0, slv_base = '0;
  logic mst_ack, slv_ack, vec_valid;
  logic [7:0] vec_out;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] held_vec = '0;

  always #2.5 clk = ~clk;

  casc_vec_gen i_casc_vec_gen (
    .clk(clk), .rst(rst), .ack_req(ack_req),
    .mst_valid(mst_valid), .mst_line(mst_line),
    .slv_valid(slv_valid), .slv_line(slv_line),
    .mst_base(mst_base), .slv_base(slv_base),
    .mst_ack(mst_ack), .slv_ack(slv_ack),
    .vec_out(vec_out), .vec_valid(vec_valid)
  );

  function automatic logic [9:0] model(logic mv, logic [2:0] ml, logic sv,
                                       logic [2:0] sl, logic [4:0] mb, logic [4:0] sb);
    if (!mv)          return {1'b0, 1'b0, mb, 3'd7};
    else if (ml != 2) return {1'b1, 1'b0, mb, ml};
    else if (sv)      return {1'b1, 1'b1, sb, sl};
    else              return {1'b1, 1'b0, sb, 3'd7};
  endfunction

  function automatic string tag_of(logic mv, logic [2:0] ml, logic sv);
    if (!mv)          return "R2";
    else if (ml != 2) return "R3";
    else if (sv)      return "R4";
    else              return "R5";
  endfunction

  task automatic check(string tag, logic [10:0] act, logic [10:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {valid,mack,sack,vec} actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at negedge, registered at next posedge, sample at following negedge
  task automatic step(logic rq, logic mv, logic [2:0] ml, logic sv,
                      logic [2:0] sl, logic [4:0] mb, logic [4:0] sb);
    logic [9:0] e;
    ack_req = rq; mst_valid = mv; mst_line = ml;
    slv_valid = sv; slv_line = sl; mst_base = mb; slv_base = sb;
    e = model(mv, ml, sv, sl, mb, sb);
    @(negedge clk);
    if (rq) begin
      held_vec = e[7:0];
      check(tag_of(mv, ml, sv), {vec_valid, mst_ack, slv_ack, vec_out}, {1'b1, e[9:8], e[7:0]});
      // R7 slave strobe only together with master strobe
      check("R7", {10'd0, slv_ack & ~mst_ack}, 11'd0);
    end else begin
      // R6 no pulse, R8 strobes idle and vector held
      check("R8", {vec_valid, mst_ack, slv_ack, vec_out}, {3'b000, held_vec});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", {vec_valid, mst_ack, slv_ack, vec_out}, 11'd0);
    rst = 1'b0;
    // directed corners
    step(1, 0, 3'd4, 1, 3'd5, 5'h03, 5'h11);  // R2
    step(1, 1, 3'd0, 1, 3'd6, 5'h1f, 5'h02);  // R3 line 0
    step(1, 1, 3'd7, 0, 3'd1, 5'h08, 5'h02);  // R3 line 7
    step(1, 1, 3'd2, 1, 3'd3, 5'h01, 5'h15);  // R4
    step(1, 1, 3'd2, 1, 3'd7, 5'h01, 5'h1f);  // R4 slave line 7
    step(1, 1, 3'd2, 0, 3'd4, 5'h0a, 5'h0c);  // R5
    // R8 idle with inputs moving
    step(0, 1, 3'd2, 1, 3'd1, 5'h1e, 5'h1d);
    step(0, 0, 3'd6, 0, 3'd0, 5'h00, 5'h00);
    // R6 back-to-back requests with different results
    step(1, 1, 3'd5, 0, 3'd0, 5'h04, 5'h09);
    step(1, 1, 3'd2, 1, 3'd0, 5'h04, 5'h09);
    step(1, 0, 3'd2, 1, 3'd0, 5'h04, 5'h09);
    // constrained random, biased toward the cascade line
    for (int i = 0; i < 600; i++) begin
      logic [2:0] ml;
      ml = ($urandom % 3 == 0) ? 3'd2 : 3'($urandom);
      step(($urandom % 4) != 0, 1'($urandom), ml, 1'($urandom), 3'($urandom),
           5'($urandom), 5'($urandom));
    end
    // R1 reset mid-run clears outputs
    rst = 1'b1;
    @(negedge clk);
    check("R1", {vec_valid, mst_ack, slv_ack, vec_out}, 11'd0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule